// File: doc/BRIEF.md
# Converter Start-Up and Brown-Out Sequencer

This block is the supervisory state machine of an offline switching controller. It decides when the power stage may switch. It reads four synchronous comparator flags: supply above the turn-on level, supply below the turn-off level, bulk-voltage image healthy, and soft-start ramp complete. From these it drives the switch that grounds the soft-start capacitor, the enable of the soft-start charge current, the enable of the brown-out hysteresis current sink, a run enable to the PWM core, and a one-cycle clear pulse to the overload fault latch.

When the supply first rises past its turn-on level, the block inserts a fixed power-up wait. The default is 120 ms with a 1 µs tick from a 100 MHz clock. During that wait the soft-start capacitor is held discharged. When the wait ends, soft start begins only if the input is healthy; otherwise the block waits for the input. A brown-out drop during soft start or run stops switching at once, discharges the capacitor and clears the fault latch. Recovery from such a drop restarts soft start directly, without repeating the power-up wait. Undervoltage on the supply returns the block to its idle state from any state.

All outputs are registered. Each output reflects the inputs sampled at the previous clock edge.

Top module: `supply_sequencer`

## Requirements
- R1: While reset is high and on the first edge after it, run_en_o, ss_charge_en_o, bo_hyst_en_o and fault_clr_o are 0 and ss_discharge_o is 1.
- R2: When vcc_low_i is 1 at a clock edge, from any state, the next outputs are run_en_o=0, ss_charge_en_o=0, ss_discharge_o=1, bo_hyst_en_o=0 and fault_clr_o=0, and the block is idle. While idle with vcc_on_i at 0, the outputs do not change.
- R3: When vcc_on_i is 1 while idle, the power-up wait starts. The outputs keep ss_discharge_o=1 and run_en_o=0 for exactly TICK_DIV*DELAY_TICKS edges after the edge that started the wait.
- R4: If bo_ok_i is 1 at the edge that ends the wait, soft start begins on that edge: run_en_o=1, ss_charge_en_o=1, ss_discharge_o=0. ss_charge_en_o and ss_discharge_o are never 1 together.
- R5: If bo_ok_i is 0 when the wait ends, run_en_o stays 0 and ss_discharge_o stays 1. Soft start begins at the first edge at which bo_ok_i is 1. run_en_o only rises after an edge that sampled bo_ok_i=1.
- R6: During soft start or run, bo_ok_i=0 at an edge gives run_en_o=0, ss_charge_en_o=0 and ss_discharge_o=1 on that edge. A later bo_ok_i=1 restarts soft start on the next edge, with no power-up wait.
- R7: The brown-out exit of R6 drives fault_clr_o to 1 for exactly one cycle. Undervoltage does not drive fault_clr_o.
- R8: bo_hyst_en_o equals the inverse of bo_ok_i at the previous edge whenever the block is not idle, and is 0 when idle.
- R9: During soft start, ss_done_i=1 moves the block to run: ss_charge_en_o drops to 0 while run_en_o stays 1 and ss_discharge_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vcc_on_i | input | 1 | Supply is above the turn-on level |
| vcc_low_i | input | 1 | Supply is below the turn-off level |
| bo_ok_i | input | 1 | Bulk-voltage image is above the brown-out reference |
| ss_done_i | input | 1 | Soft-start ramp has reached its completion level |
| ss_discharge_o | output | 1 | Closes the switch that grounds the soft-start capacitor |
| ss_charge_en_o | output | 1 | Enables the soft-start charge current |
| bo_hyst_en_o | output | 1 | Enables the brown-out hysteresis current sink |
| run_en_o | output | 1 | Lets the PWM core switch |
| fault_clr_o | output | 1 | One-cycle clear of the overload fault latch |

## Verification
Two events can land on the same edge. One is the end of the power-up wait. The other is a change of bo_ok_i: for example, the input turning healthy on the very edge where the wait expires, or dropping on that edge.

The bench lowers bo_ok_i before the expiry edge and raises it on the edge right after it. It then checks that soft start appears one edge later and not earlier.

It also collides undervoltage with a brown-out drop on one edge. There, undervoltage must win: the block goes idle with no fault-clear pulse.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [2:0] {
    SEQ_OFF   = 3'd0,
    SEQ_DELAY = 3'd1,
    SEQ_WAIT  = 3'd2,
    SEQ_SOFT  = 3'd3,
    SEQ_RUN   = 3'd4
  } seq_state_t;

  function automatic logic is_switching(input seq_state_t s);
    return (s == SEQ_SOFT) || (s == SEQ_RUN);
  endfunction
endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int TICK_DIV    = 100,
  parameter int DELAY_TICKS = 120000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;

  logic          tick;
  logic [CW-1:0] cnt_q;

  generate
    if (TICK_DIV > 1) begin : g_pre
      localparam int PW = $clog2(TICK_DIV);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst || !run_i)               pre_q <= '0;
        else if (pre_q == PW'(TICK_DIV - 1)) pre_q <= '0;
        else                             pre_q <= pre_q + 1'b1;
      end
      assign tick = run_i && (pre_q == PW'(TICK_DIV - 1));
    end else begin : g_nopre
      assign tick = run_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt_q <= '0;
    else if (tick)     cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = tick && (cnt_q == CW'(DELAY_TICKS - 1));
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       vcc_on_i,
  input  logic       vcc_low_i,
  input  logic       bo_ok_i,
  input  logic       ss_done_i,
  input  logic       expire_i,
  output seq_state_t state_q,
  output seq_state_t state_d,
  output logic       bo_exit_o
);
  always_comb begin
    state_d   = state_q;
    bo_exit_o = 1'b0;
    if (vcc_low_i) begin
      state_d = SEQ_OFF;
    end else begin
      unique case (state_q)
        SEQ_OFF:   if (vcc_on_i) state_d = SEQ_DELAY;
        SEQ_DELAY: if (expire_i) state_d = bo_ok_i ? SEQ_SOFT : SEQ_WAIT;
        SEQ_WAIT:  if (bo_ok_i)  state_d = SEQ_SOFT;
        SEQ_SOFT: begin
          if (!bo_ok_i) begin
            state_d   = SEQ_WAIT;
            bo_exit_o = 1'b1;
          end else if (ss_done_i) begin
            state_d = SEQ_RUN;
          end
        end
        SEQ_RUN: begin
          if (!bo_ok_i) begin
            state_d   = SEQ_WAIT;
            bo_exit_o = 1'b1;
          end
        end
        default: state_d = SEQ_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEQ_OFF;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/pwrseq_outreg.sv
module pwrseq_outreg
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_t state_d,
  input  logic       bo_ok_i,
  input  logic       bo_exit_i,
  output logic       ss_discharge_o,
  output logic       ss_charge_en_o,
  output logic       bo_hyst_en_o,
  output logic       run_en_o,
  output logic       fault_clr_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ss_discharge_o <= 1'b1;
      ss_charge_en_o <= 1'b0;
      bo_hyst_en_o   <= 1'b0;
      run_en_o       <= 1'b0;
      fault_clr_o    <= 1'b0;
    end else begin
      ss_discharge_o <= !is_switching(state_d);
      ss_charge_en_o <= (state_d == SEQ_SOFT);
      bo_hyst_en_o   <= !bo_ok_i && (state_d != SEQ_OFF);
      run_en_o       <= is_switching(state_d);
      fault_clr_o    <= bo_exit_i;
    end
  end
endmodule

// File: rtl/supply_sequencer.sv
module supply_sequencer
  import pwrseq_pkg::*;
#(
  parameter int TICK_DIV    = 100,
  parameter int DELAY_TICKS = 120000
) (
  input  logic clk,
  input  logic rst,
  input  logic vcc_on_i,
  input  logic vcc_low_i,
  input  logic bo_ok_i,
  input  logic ss_done_i,
  output logic ss_discharge_o,
  output logic ss_charge_en_o,
  output logic bo_hyst_en_o,
  output logic run_en_o,
  output logic fault_clr_o
);
  seq_state_t state_q;
  seq_state_t state_d;
  logic       expire;
  logic       bo_exit;

  pwrseq_timer #(
    .TICK_DIV   (TICK_DIV),
    .DELAY_TICKS(DELAY_TICKS)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run_i   (state_q == SEQ_DELAY),
    .expire_o(expire)
  );

  pwrseq_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .vcc_on_i (vcc_on_i),
    .vcc_low_i(vcc_low_i),
    .bo_ok_i  (bo_ok_i),
    .ss_done_i(ss_done_i),
    .expire_i (expire),
    .state_q  (state_q),
    .state_d  (state_d),
    .bo_exit_o(bo_exit)
  );

  pwrseq_outreg u_out (
    .clk           (clk),
    .rst           (rst),
    .state_d       (state_d),
    .bo_ok_i       (bo_ok_i),
    .bo_exit_i     (bo_exit),
    .ss_discharge_o(ss_discharge_o),
    .ss_charge_en_o(ss_charge_en_o),
    .bo_hyst_en_o  (bo_hyst_en_o),
    .run_en_o      (run_en_o),
    .fault_clr_o   (fault_clr_o)
  );
endmodule

// File: rtl/supply_sequencer_chk.sv
module supply_sequencer_chk (
  input logic clk,
  input logic rst,
  input logic vcc_low_i,
  input logic bo_ok_i,
  input logic ss_discharge_o,
  input logic ss_charge_en_o,
  input logic bo_hyst_en_o,
  input logic run_en_o,
  input logic fault_clr_o
);
  AST_UV_STOPS: assert property (@(posedge clk) disable iff (rst)
    vcc_low_i |=> (!run_en_o && ss_discharge_o && !bo_hyst_en_o && !fault_clr_o)); // R2

  AST_CHG_NOT_DIS: assert property (@(posedge clk) disable iff (rst)
    !(ss_charge_en_o && ss_discharge_o)); // R4

  AST_RUN_NEEDS_BO: assert property (@(posedge clk) disable iff (rst)
    $rose(run_en_o) |-> $past(bo_ok_i)); // R5

  AST_BO_DROP_STOPS: assert property (@(posedge clk) disable iff (rst)
    (run_en_o && !bo_ok_i && !vcc_low_i) |=> (!run_en_o && ss_discharge_o && fault_clr_o)); // R6

  AST_FCLR_PULSE: assert property (@(posedge clk) disable iff (rst)
    fault_clr_o |=> !fault_clr_o); // R7

  AST_HYST_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    bo_hyst_en_o |-> !$past(bo_ok_i)); // R8
endmodule

bind supply_sequencer supply_sequencer_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .vcc_low_i     (vcc_low_i),
  .bo_ok_i       (bo_ok_i),
  .ss_discharge_o(ss_discharge_o),
  .ss_charge_en_o(ss_charge_en_o),
  .bo_hyst_en_o  (bo_hyst_en_o),
  .run_en_o      (run_en_o),
  .fault_clr_o   (fault_clr_o)
);

// File: tb/tb_supply_sequencer.sv
`timescale 1ns/1ps
module tb_supply_sequencer;
  localparam int TD = 4;
  localparam int DT = 5;
  localparam int WAIT_EDGES = TD * DT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vcc_on = 1'b0, vcc_low = 1'b0, bo_ok = 1'b0, ss_done = 1'b0;
  logic ss_dis, ss_chg, hyst, run_en, fclr;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  supply_sequencer #(.TICK_DIV(TD), .DELAY_TICKS(DT)) dut (
    .clk(clk), .rst(rst), .vcc_on_i(vcc_on), .vcc_low_i(vcc_low),
    .bo_ok_i(bo_ok), .ss_done_i(ss_done), .ss_discharge_o(ss_dis),
    .ss_charge_en_o(ss_chg), .bo_hyst_en_o(hyst), .run_en_o(run_en),
    .fault_clr_o(fclr)
  );

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected vector order: {dis, chg, hyst, run, clr}
  task automatic expect_out(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {ss_dis, ss_chg, hyst, run_en, fclr};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {dis,chg,hyst,run,clr} act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    vcc_on = 0; vcc_low = 0; bo_ok = 0; ss_done = 0;
    edges(3);
    expect_out("R1 in reset", 5'b10000);
    rst = 1'b0;
    edges(1);
    expect_out("R1 after reset", 5'b10000);
  endtask

  task automatic t_powerup_ok;
    bo_ok = 1; vcc_on = 1;
    edges(1);
    expect_out("R3 wait start", 5'b10000);
    edges(WAIT_EDGES - 1);
    expect_out("R3 last wait edge", 5'b10000);
    edges(1);
    expect_out("R4 soft start", 5'b01010);
    ss_done = 1;
    edges(1);
    expect_out("R9 run", 5'b00010);
    ss_done = 0;
    edges(2);
    expect_out("R9 run held", 5'b00010);
  endtask

  task automatic t_brownout;
    bo_ok = 0;
    edges(1);
    expect_out("R6 R7 bo drop", 5'b10101);
    edges(1);
    expect_out("R7 pulse ends, R8 hyst", 5'b10100);
    edges(4);
    expect_out("R6 waiting", 5'b10100);
    bo_ok = 1;
    edges(1);
    expect_out("R6 no repeat wait", 5'b01010);
  endtask

  task automatic t_uv_collide;
    vcc_low = 1; bo_ok = 0;
    edges(1);
    expect_out("R2 R7 uv wins", 5'b10000);
    vcc_low = 0; vcc_on = 0; bo_ok = 1;
    edges(5);
    expect_out("R2 idle stays", 5'b10000);
  endtask

  task automatic t_powerup_late;
    bo_ok = 0; vcc_on = 1;
    edges(1);
    expect_out("R8 hyst in wait", 5'b10100);
    edges(WAIT_EDGES);
    expect_out("R5 expiry without bo", 5'b10100);
    bo_ok = 1;
    edges(1);
    expect_out("R5 late bo starts", 5'b01010);
  endtask

  task automatic t_uv_in_delay;
    vcc_low = 1;
    edges(1);
    vcc_low = 0; vcc_on = 1; bo_ok = 1;
    edges(1);
    edges(WAIT_EDGES / 2);
    expect_out("R2 R3 restart full wait", 5'b10000);
    edges(WAIT_EDGES - WAIT_EDGES / 2 - 1);
    expect_out("R3 still waiting", 5'b10000);
    edges(1);
    expect_out("R4 after restart", 5'b01010);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_powerup_ok();
        t_brownout();
        t_uv_collide();
        t_powerup_late();
        t_uv_in_delay();
      end
      begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule